// File: doc/BRIEF.md
# Global-History Two-Level Branch Direction Predictor

This block guesses whether a conditional branch will be taken while the branch is still being fetched. A shift register holds the directions of the most recent branches. The block XORs that register with a slice of the fetch address to select one 2-bit saturating counter in a table. The upper bit of the selected counter is the guess. The fetch unit receives the guess together with the table index that produced it. It carries that index down the pipeline and hands it back when the branch commits, together with the real outcome and a flag that marks a wrong guess.

Training happens only at commit, but guesses are made at fetch. For that reason the block keeps two histories. The speculative history takes in each guessed direction as soon as the guess is made. The committed history takes in only real outcomes. When a wrong guess commits, the speculative history is rebuilt from the committed history plus the correct outcome. This discards whatever the wrong path shifted in.

Top module: `gp_predictor`

## Requirements
- R1: After reset, every counter holds weakly-taken (binary 10) and both histories are all zero. Any fetch address is therefore predicted taken, and its index equals its own address slice.
- R2: The index returned on `pred_index` equals the speculative history XOR the address bits `pred_pc[ALIGN+HIST_W-1:ALIGN]`. It is computed combinationally in the same cycle.
- R3: `pred_taken` is bit 1 of the counter selected by `pred_index` (1 = taken).
- R4: On a clock edge with `pred_valid` high, the speculative history shifts left by one place. The new `pred_taken` enters at bit 0, the newest position.
- R5: A commit with `ret_taken` = 1 increments the counter at `ret_index`. A counter already at 3 stays at 3.
- R6: A commit with `ret_taken` = 0 decrements the counter at `ret_index`. A counter already at 0 stays at 0.
- R7: A commit with `ret_mispredict` = 1 loads the speculative history with the committed history shifted left, with `ret_taken` at bit 0. This takes priority over a prediction in the same cycle.
- R8: Every commit shifts `ret_taken` into bit 0 of the committed history. Cycles without a commit leave that history unchanged.
- R9: When a commit and a prediction address the same counter in the same cycle, the prediction sees the counter value from before the update.
- R10: A single branch whose outcomes alternate taken and not-taken is predicted correctly on every instance once both of its history patterns have been trained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pred_valid | input | 1 | A conditional branch is being fetched this cycle |
| pred_pc | input | PC_W | Fetch address of that branch |
| pred_taken | output | 1 | Guessed direction (1 = taken) |
| pred_index | output | HIST_W | Table index used for the guess, to be returned at commit |
| ret_valid | input | 1 | A conditional branch commits this cycle |
| ret_index | input | HIST_W | Index that was returned with this branch's guess |
| ret_taken | input | 1 | Real direction of the committing branch |
| ret_mispredict | input | 1 | The guess for this branch was wrong |

## Verification
The embedded properties check these on every cycle:
- the speculative history shifts correctly on each guess;
- the committed history shifts correctly on each commit and holds when there is none;
- both histories are equal immediately after a repair;
- each counter steps by one in the trained direction and stops at its limits.

Some behaviours appear only in the bench's scenarios. These are the index hash against chosen addresses, the pre-update value seen on a same-cycle read of a counter being trained, and a repair that overrides a wrong-path guess in the same cycle. The bench also shows the reset value returning after training and an alternating branch reaching perfect prediction.

// File: rtl/gp_pkg.sv
package gp_pkg;

    typedef logic [1:0] ctr_t;

    localparam ctr_t CTR_MIN    = 2'b00;
    localparam ctr_t CTR_MAX    = 2'b11;
    localparam ctr_t CTR_WEAK_T = 2'b10;

    // one committing branch, as seen by the history and table logic
    typedef struct packed {
        logic valid;
        logic taken;
        logic mispredict;
    } commit_t;

    // saturating step of a direction counter
    function automatic ctr_t ctr_step(ctr_t c, logic taken);
        ctr_t n;
        if (taken) n = (c == CTR_MAX) ? CTR_MAX : c + 2'd1;
        else       n = (c == CTR_MIN) ? CTR_MIN : c - 2'd1;
        return n;
    endfunction

    function automatic logic ctr_dir(ctr_t c);
        return c[1];
    endfunction

endpackage

// File: rtl/gp_index_hash.sv
module gp_index_hash #(
    parameter int PC_W   = 32,
    parameter int HIST_W = 8,
    parameter int ALIGN  = 2
) (
    input  logic [PC_W-1:0]   pc,
    input  logic [HIST_W-1:0] hist,
    output logic [HIST_W-1:0] index
);

    localparam int LO = ALIGN;
    localparam int HI = ALIGN + HIST_W - 1;

    logic unused_pc_bits;
    assign unused_pc_bits = ^{pc[PC_W-1:HI+1], pc[LO-1:0]};

    assign index = hist ^ pc[HI:LO];

endmodule

// File: rtl/gp_history.sv
module gp_history
    import gp_pkg::*;
#(
    parameter int HIST_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pred_fire,
    input  logic              pred_dir,
    input  commit_t           cmt,
    output logic [HIST_W-1:0] spec_q,
    output logic [HIST_W-1:0] ret_q
);

    logic [HIST_W-1:0] ret_next;
    logic              repair;

    assign ret_next = {ret_q[HIST_W-2:0], cmt.taken};
    assign repair   = cmt.valid && cmt.mispredict;

    always_ff @(posedge clk) begin
        if (rst) begin
            ret_q <= '0;
        end else if (cmt.valid) begin
            ret_q <= ret_next;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            spec_q <= '0;
        end else if (repair) begin
            spec_q <= ret_next;
        end else if (pred_fire) begin
            spec_q <= {spec_q[HIST_W-2:0], pred_dir};
        end
    end

    // R4: guessed direction enters at the newest end
    a_r4_spec_shift: assert property (@(posedge clk) disable iff (rst)
        (pred_fire && !repair) |=>
            (spec_q[0] == $past(pred_dir)) &&
            (spec_q[HIST_W-1:1] == $past(spec_q[HIST_W-2:0])));

    // R7: after a repair both histories agree
    a_r7_repair_match: assert property (@(posedge clk) disable iff (rst)
        repair |=> (spec_q == ret_q));

    // R8: committed history takes the real outcome
    a_r8_commit_shift: assert property (@(posedge clk) disable iff (rst)
        cmt.valid |=> (ret_q[0] == $past(cmt.taken)) &&
                      (ret_q[HIST_W-1:1] == $past(ret_q[HIST_W-2:0])));

    a_r8_commit_hold: assert property (@(posedge clk) disable iff (rst)
        !cmt.valid |=> $stable(ret_q));

endmodule

// File: rtl/gp_counter_table.sv
module gp_counter_table
    import gp_pkg::*;
#(
    parameter int HIST_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [HIST_W-1:0] rd_index,
    output logic              rd_dir,
    input  commit_t           cmt,
    input  logic [HIST_W-1:0] wr_index
);

    localparam int DEPTH = 1 << HIST_W;

    ctr_t cnt_q [DEPTH];

    // read sees the stored value, so a same-cycle update is not visible
    assign rd_dir = ctr_dir(cnt_q[rd_index]);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                cnt_q[i] <= CTR_WEAK_T;
            end
        end else if (cmt.valid) begin
            cnt_q[wr_index] <= ctr_step(cnt_q[wr_index], cmt.taken);
        end
    end

    // R5: increment and ceiling
    a_r5_inc: assert property (@(posedge clk) disable iff (rst)
        (cmt.valid && cmt.taken && cnt_q[wr_index] != CTR_MAX) |=>
            cnt_q[$past(wr_index)] == $past(cnt_q[wr_index]) + 2'd1);

    a_r5_ceiling: assert property (@(posedge clk) disable iff (rst)
        (cmt.valid && cmt.taken && cnt_q[wr_index] == CTR_MAX) |=>
            cnt_q[$past(wr_index)] == CTR_MAX);

    // R6: decrement and floor
    a_r6_dec: assert property (@(posedge clk) disable iff (rst)
        (cmt.valid && !cmt.taken && cnt_q[wr_index] != CTR_MIN) |=>
            cnt_q[$past(wr_index)] == $past(cnt_q[wr_index]) - 2'd1);

    a_r6_floor: assert property (@(posedge clk) disable iff (rst)
        (cmt.valid && !cmt.taken && cnt_q[wr_index] == CTR_MIN) |=>
            cnt_q[$past(wr_index)] == CTR_MIN);

endmodule

// File: rtl/gp_predictor.sv
module gp_predictor
    import gp_pkg::*;
#(
    parameter int PC_W   = 32,
    parameter int HIST_W = 8,
    parameter int ALIGN  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pred_valid,
    input  logic [PC_W-1:0]   pred_pc,
    output logic              pred_taken,
    output logic [HIST_W-1:0] pred_index,
    input  logic              ret_valid,
    input  logic [HIST_W-1:0] ret_index,
    input  logic              ret_taken,
    input  logic              ret_mispredict
);

    commit_t           cmt;
    logic [HIST_W-1:0] spec_hist;
    logic [HIST_W-1:0] ret_hist;

    assign cmt = '{valid: ret_valid, taken: ret_taken, mispredict: ret_mispredict};

    gp_index_hash #(.PC_W(PC_W), .HIST_W(HIST_W), .ALIGN(ALIGN)) u_hash (
        .pc    (pred_pc),
        .hist  (spec_hist),
        .index (pred_index)
    );

    gp_counter_table #(.HIST_W(HIST_W)) u_table (
        .clk      (clk),
        .rst      (rst),
        .rd_index (pred_index),
        .rd_dir   (pred_taken),
        .cmt      (cmt),
        .wr_index (ret_index)
    );

    gp_history #(.HIST_W(HIST_W)) u_hist (
        .clk       (clk),
        .rst       (rst),
        .pred_fire (pred_valid),
        .pred_dir  (pred_taken),
        .cmt       (cmt),
        .spec_q    (spec_hist),
        .ret_q     (ret_hist)
    );

    logic unused_ret_hist;
    assign unused_ret_hist = ^ret_hist;

endmodule

// File: tb/gp_predictor_tb.sv
`timescale 1ns/1ps
module gp_predictor_tb;

    localparam int PC_W = 32;
    localparam int HW   = 8;

    typedef struct packed {
        logic          pv;
        logic [31:0]   pc;
        logic          rv;
        logic [7:0]    ridx;
        logic          rt;
        logic          rm;
        logic          et;
        logic [7:0]    ei;
    } vec_t;

    // expected outputs are those seen before the edge that applies the row
    localparam vec_t VECS [8] = '{
        '{1'b1, 32'h10, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'h04}, // R1 R2 R4
        '{1'b1, 32'h10, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'h05}, // R2 R4
        '{1'b0, 32'h10, 1'b1, 8'h04, 1'b0, 1'b1, 1'b1, 8'h07}, // R6 R7
        '{1'b1, 32'h10, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h04}, // R3 R7
        '{1'b1, 32'h10, 1'b1, 8'h04, 1'b1, 1'b0, 1'b0, 8'h04}, // R9
        '{1'b1, 32'h10, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'h04}, // R5 R9
        '{1'b1, 32'h20, 1'b1, 8'h05, 1'b1, 1'b1, 1'b1, 8'h09}, // R7 R8
        '{1'b1, 32'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'h03}  // R7 R8
    };

    logic            clk = 1'b0;
    logic            rst;
    logic            pred_valid;
    logic [PC_W-1:0] pred_pc;
    logic            pred_taken;
    logic [HW-1:0]   pred_index;
    logic            ret_valid;
    logic [HW-1:0]   ret_index;
    logic            ret_taken;
    logic            ret_mispredict;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    gp_predictor #(.PC_W(PC_W), .HIST_W(HW), .ALIGN(2)) u_dut (
        .clk            (clk),
        .rst            (rst),
        .pred_valid     (pred_valid),
        .pred_pc        (pred_pc),
        .pred_taken     (pred_taken),
        .pred_index     (pred_index),
        .ret_valid      (ret_valid),
        .ret_index      (ret_index),
        .ret_taken      (ret_taken),
        .ret_mispredict (ret_mispredict)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // drive one cycle of inputs at the falling edge, settle before the rise
    task automatic drive(logic pv, logic [31:0] pc, logic rv, logic [7:0] ri,
                         logic rt, logic rm);
        @(negedge clk);
        pred_valid = pv; pred_pc = pc;
        ret_valid = rv; ret_index = ri; ret_taken = rt; ret_mispredict = rm;
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        pred_valid = 0; pred_pc = '0; ret_valid = 0; ret_index = '0;
        ret_taken = 0; ret_mispredict = 0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        do_reset();

        // R1: reset state for a few addresses
        drive(0, 32'h0000_0008, 0, 0, 0, 0);
        chk("R1 taken", pred_taken, 1);
        chk("R1 index", pred_index, 8'h02);
        drive(0, 32'hFFFF_FFFC, 0, 0, 0, 0);
        chk("R1 taken", pred_taken, 1);
        chk("R1 index", pred_index, 8'hFF);

        // vector table
        for (int i = 0; i < 8; i++) begin
            drive(VECS[i].pv, VECS[i].pc, VECS[i].rv, VECS[i].ridx,
                  VECS[i].rt, VECS[i].rm);
            chk($sformatf("R3 vec%0d taken", i), pred_taken, VECS[i].et);
            chk($sformatf("R2 vec%0d index", i), pred_index, VECS[i].ei);
        end
        // speculative history is now 8'h07; counter 5 holds 3

        // R5: ceiling at 3 (two more taken commits, then one not-taken)
        drive(0, 0, 1, 8'h05, 1, 0);
        drive(0, 0, 1, 8'h05, 1, 0);
        drive(0, 0, 1, 8'h05, 0, 0);
        drive(0, 32'h08, 0, 0, 0, 0);
        chk("R5 ceiling index", pred_index, 8'h05);
        chk("R5 ceiling taken", pred_taken, 1);
        drive(0, 0, 1, 8'h05, 0, 0);
        drive(0, 32'h08, 0, 0, 0, 0);
        chk("R6 decrement to 1", pred_taken, 0);

        // R6: floor at 0
        drive(0, 0, 1, 8'h05, 0, 0);
        drive(0, 0, 1, 8'h05, 0, 0);
        drive(0, 0, 1, 8'h05, 0, 0);
        drive(0, 0, 1, 8'h05, 1, 0);
        drive(0, 32'h08, 0, 0, 0, 0);
        chk("R6 floor", pred_taken, 0);
        drive(0, 0, 1, 8'h05, 1, 0);
        drive(0, 32'h08, 0, 0, 0, 0);
        chk("R5 increment to 2", pred_taken, 1);

        // R8: commits without mispredict leave speculative history alone
        chk("R8 spec untouched index", pred_index, 8'h05);

        // R1: reset restores counters and histories after training
        do_reset();
        drive(0, 32'h10, 0, 0, 0, 0);
        chk("R1 reset index", pred_index, 8'h04);
        chk("R1 reset taken", pred_taken, 1);

        // R10: alternating single branch
        for (int it = 0; it < 40; it++) begin
            logic out;
            logic pt;
            logic [7:0] pi;
            out = (it % 2 == 0);
            drive(1, 32'h40, 0, 0, 0, 0);
            pt = pred_taken;
            pi = pred_index;
            if (it >= 24) chk($sformatf("R10 iter%0d", it), pt, out);
            drive(0, 32'h40, 1, pi, out, pt != out);
        end
        drive(0, 0, 0, 0, 0, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule